// File: doc/BRIEF.md
# MESI Snooping Cache State Controller

This block is the coherence controller that sits beside one core's small direct-mapped cache. Each line holds a tag, a single data word and a two-bit coherence state. On the core side it accepts read and write requests over a valid/ready handshake. It answers hits locally. When the core needs something from the bus, it issues a bus read, a read-for-ownership or an upgrade (invalidate broadcast). If a dirty victim is being replaced, it writes that victim back first.

On the snoop side, the block watches transactions issued by other caches. It raises a shared or dirty response in the same cycle and moves the snooped line to its new state. Data never passes from one cache to another. A snoop that hits a Modified line causes a write-back to memory, and the requester then re-reads memory. The bus grants one request at a time, and the bus command is held until the grant arrives. After this block raises the dirty response, the bus issues no further snoop to it until that write-back has been granted.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid, core_req_ready is high, bus_req_valid is low and neither snoop response is raised. Line states are encoded I=0, S=1, E=2, M=3. The low log2(LINES) address bits select the line and the remaining bits form the tag.
- R2: A read miss issues a bus read (bus_req_cmd 0). The line is filled from bus_rdata in Exclusive if bus_shared_in is low at the grant, or in Shared if it is high. The core response carries the filled word.
- R3: A read hit returns the stored word with core_rsp_valid, as a one-cycle pulse in the cycle after acceptance, with no bus request.
- R4: A write hit on an Exclusive or Modified line stores the data and leaves the line Modified with no bus request. The response echoes the written word.
- R5: A write hit on a Shared line issues an upgrade (bus_req_cmd 2). At the grant it stores the data and marks the line Modified.
- R6: A write miss issues a read-for-ownership (bus_req_cmd 1). At the grant the line takes the new tag and the write data, and becomes Modified.
- R7: A miss whose victim line is Modified first issues a write-back (bus_req_cmd 3) of the victim's address and word, and only then the fill. A clean victim is dropped without a write-back.
- R8: A snooped bus read (snp_cmd 0) that hits an Exclusive or Shared line raises snp_shared, and the line ends Shared.
- R9: A snooped bus read that hits a Modified line raises snp_dirty, writes the line's word back to its address with a bus write-back, and leaves the line Shared.
- R10: A snooped upgrade or read-for-ownership (snp_cmd 2 or 1) that hits a Shared or Exclusive line makes it Invalid with no response. If it hits a Modified line, the block raises snp_dirty, writes the line back and leaves it Invalid.
- R11: A snoop that misses on the tag, or hits an Invalid line, raises no response and changes no state.
- R12: In any cycle with snp_valid high, core_req_ready and bus_req_valid are low and the snoop is applied first. A pending upgrade whose line was invalidated by that snoop is reissued as a read-for-ownership.
- R13: While bus_req_valid is high without a grant and no snoop intervenes, bus_req_cmd and bus_req_addr stay unchanged into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_req_valid | input | 1 | Core request present |
| core_req_ready | output | 1 | Controller can accept a request |
| core_req_we | input | 1 | 1 = write, 0 = read |
| core_req_addr | input | ADDR_W | Word address |
| core_req_wdata | input | DATA_W | Write word |
| core_rsp_valid | output | 1 | Request complete (one-cycle pulse) |
| core_rsp_rdata | output | DATA_W | Read word, or the written word for a write |
| bus_req_valid | output | 1 | Bus transaction requested |
| bus_req_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 write-back |
| bus_req_addr | output | ADDR_W | Transaction address |
| bus_req_wdata | output | DATA_W | Write-back word |
| bus_gnt | input | 1 | Grant; the transaction completes in this cycle |
| bus_rdata | input | DATA_W | Memory word for a fill, valid with the grant |
| bus_shared_in | input | 1 | Another cache holds the line, valid with the grant |
| snp_valid | input | 1 | Snooped transaction from another cache |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_req_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds a clean copy |
| snp_dirty | output | 1 | This cache holds a Modified copy and will write it back |

## Verification
The hardest case to reach is the race where a write hit on a Shared line is waiting for its upgrade grant and a snooped invalidation of the same line arrives first. The stimulus accepts the write, then presents the snooped upgrade in the very next cycle, before any grant. It checks that the request is withheld during the snoop and comes back as a read-for-ownership. The other hidden states (E versus S versus M) are exposed through the ports. A later snoop's response or a later core write's bus command reveals which state the line was left in. A held-off grant shows that the request is stable.

// File: rtl/mesi_pkg.sv
// Shared encodings for the coherence controller.
// Assumes a two-bit state per line and a two-bit bus command.
package mesi_pkg;
    typedef enum logic [1:0] {
        ST_I = 2'd0,
        ST_S = 2'd1,
        ST_E = 2'd2,
        ST_M = 2'd3
    } mesi_t;

    typedef enum logic [1:0] {
        CMD_RD  = 2'd0,
        CMD_RFO = 2'd1,
        CMD_UPG = 2'd2,
        CMD_WB  = 2'd3
    } bus_cmd_t;
endpackage

// File: rtl/mesi_line_store.sv
// Tag, word and coherence state storage for a direct-mapped set of lines.
// Two read ports (core side, snoop side). The snoop port may only change the
// state; the core port rewrites tag, state and optionally the word.
// Assumes both write ports never target the same line in one cycle; the
// snoop port wins if they do.
module mesi_line_store
    import mesi_pkg::*;
#(
    parameter int LINES  = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [$clog2(LINES)-1:0] c_idx,
    output logic [TAG_W-1:0]         c_tag,
    output mesi_t                    c_state,
    output logic [DATA_W-1:0]        c_data,
    input  logic                     cw_en,
    input  logic [TAG_W-1:0]         cw_tag,
    input  mesi_t                    cw_state,
    input  logic                     cw_data_en,
    input  logic [DATA_W-1:0]        cw_data,
    input  logic [$clog2(LINES)-1:0] s_idx,
    output logic [TAG_W-1:0]         s_tag,
    output mesi_t                    s_state,
    output logic [DATA_W-1:0]        s_data,
    input  logic                     sw_en,
    input  mesi_t                    sw_state
);
    localparam int IDX_W = $clog2(LINES);

    logic [TAG_W-1:0]  tag_q  [LINES];
    mesi_t             st_q   [LINES];
    logic [DATA_W-1:0] data_q [LINES];

    // Read ports: plain indexed lookups.
    assign c_tag   = tag_q[c_idx];
    assign c_state = st_q[c_idx];
    assign c_data  = data_q[c_idx];
    assign s_tag   = tag_q[s_idx];
    assign s_state = st_q[s_idx];
    assign s_data  = data_q[s_idx];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Per-line update: snoop state change first, then the core-side rewrite.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_q[g]   <= ST_I;
                tag_q[g]  <= '0;
                data_q[g] <= '0;
            end else if (sw_en && s_idx == IDX_W'(g)) begin
                st_q[g] <= sw_state;
            end else if (cw_en && c_idx == IDX_W'(g)) begin
                st_q[g]  <= cw_state;
                tag_q[g] <= cw_tag;
                if (cw_data_en) data_q[g] <= cw_data;
            end
        end
    end

    // R7
    no_dirty_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cw_en && st_q[c_idx] == ST_M && tag_q[c_idx] != cw_tag));
endmodule

// File: rtl/mesi_snoop.sv
// Snoop responder: compares a snooped address with the addressed line,
// raises shared/dirty, picks the line's next state and holds one pending
// write-back for a snooped Modified line until the bus grants it.
// Assumes the bus sends no new snoop while a write-back is pending.
module mesi_snoop
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              snp_valid,
    input  bus_cmd_t          snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  mesi_t             line_state,
    input  logic [DATA_W-1:0] line_data,
    output logic              shared,
    output logic              dirty,
    output logic              sw_en,
    output mesi_t             sw_state,
    output logic              wb_pend,
    output logic [ADDR_W-1:0] wb_addr,
    output logic [DATA_W-1:0] wb_data,
    input  logic              wb_done
);
    logic hit, wb_start;

    // Response and next-state decision for the snooped line.
    always_comb begin
        hit      = snp_valid && line_state != ST_I && line_tag == snp_addr[ADDR_W-1:IDX_W];
        shared   = 1'b0;
        dirty    = 1'b0;
        sw_en    = 1'b0;
        sw_state = line_state;
        wb_start = 1'b0;
        if (hit) begin
            case (snp_cmd)
                CMD_RD: begin
                    sw_en    = 1'b1;
                    sw_state = ST_S;
                    if (line_state == ST_M) begin
                        dirty    = 1'b1;
                        wb_start = 1'b1;
                    end else begin
                        shared = 1'b1;
                    end
                end
                CMD_RFO, CMD_UPG: begin
                    sw_en    = 1'b1;
                    sw_state = ST_I;
                    if (line_state == ST_M) begin
                        dirty    = 1'b1;
                        wb_start = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    // Pending write-back register, set by a dirty hit, cleared by its grant.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_pend <= 1'b0;
            wb_addr <= '0;
            wb_data <= '0;
        end else if (wb_start) begin
            wb_pend <= 1'b1;
            wb_addr <= snp_addr;
            wb_data <= line_data;
        end else if (wb_done) begin
            wb_pend <= 1'b0;
        end
    end

    // R11
    quiet_without_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !snp_valid |-> !shared && !dirty);
endmodule

// File: rtl/mesi_core_fsm.sv
// Core request sequencer: accepts one request, serves hits locally and
// otherwise drives the bus command (write-back victim, read, read-for-
// ownership or upgrade), updating the line at each grant.
// Assumes bgnt arrives only while its own request is on the bus.
module mesi_core_fsm
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_we,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              snp_valid,
    input  logic              wb_pend,
    output logic [IDX_W-1:0]  c_idx,
    input  logic [ADDR_W-IDX_W-1:0] line_tag,
    input  mesi_t             line_state,
    input  logic [DATA_W-1:0] line_data,
    output logic              cw_en,
    output logic [ADDR_W-IDX_W-1:0] cw_tag,
    output mesi_t             cw_state,
    output logic              cw_data_en,
    output logic [DATA_W-1:0] cw_data,
    output logic              breq_valid,
    output bus_cmd_t          breq_cmd,
    output logic [ADDR_W-1:0] breq_addr,
    output logic [DATA_W-1:0] breq_wdata,
    input  logic              bgnt,
    input  logic [DATA_W-1:0] brdata,
    input  logic              bshared
);
    localparam int TAG_W = ADDR_W - IDX_W;
    typedef enum logic {F_IDLE, F_ACT} fsm_t;

    fsm_t              st_q;
    logic              we_q;
    logic [TAG_W-1:0]  tag_q;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] wdata_q;
    logic              hit, local_ok, finish;
    logic [DATA_W-1:0] rdata_n;

    assign c_idx     = idx_q;
    assign req_ready = st_q == F_IDLE && !snp_valid && !wb_pend;

    // Hit test, bus command choice and line update for the active request.
    always_comb begin
        hit        = line_state != ST_I && line_tag == tag_q;
        local_ok   = hit && (!we_q || line_state == ST_M || line_state == ST_E);
        if (hit)                    breq_cmd = CMD_UPG;
        else if (line_state == ST_M) breq_cmd = CMD_WB;
        else                        breq_cmd = we_q ? CMD_RFO : CMD_RD;
        breq_valid = st_q == F_ACT && !local_ok;
        breq_addr  = (breq_cmd == CMD_WB) ? {line_tag, idx_q} : {tag_q, idx_q};
        breq_wdata = line_data;
        cw_en      = 1'b0;
        cw_tag     = tag_q;
        cw_state   = ST_M;
        cw_data_en = 1'b0;
        cw_data    = wdata_q;
        finish     = 1'b0;
        rdata_n    = wdata_q;
        if (st_q == F_ACT && !snp_valid) begin
            if (local_ok) begin
                finish = 1'b1;
                if (we_q) begin
                    cw_en      = 1'b1;
                    cw_data_en = 1'b1;
                end else begin
                    rdata_n = line_data;
                end
            end else if (bgnt) begin
                cw_en = 1'b1;
                case (breq_cmd)
                    CMD_WB: begin
                        cw_tag   = line_tag;
                        cw_state = ST_I;
                    end
                    CMD_RD: begin
                        cw_state   = bshared ? ST_S : ST_E;
                        cw_data_en = 1'b1;
                        cw_data    = brdata;
                        rdata_n    = brdata;
                        finish     = 1'b1;
                    end
                    default: begin
                        cw_data_en = 1'b1;
                        finish     = 1'b1;
                    end
                endcase
            end
        end
    end

    // Request capture, completion and response register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= F_IDLE;
            we_q      <= 1'b0;
            tag_q     <= '0;
            idx_q     <= '0;
            wdata_q   <= '0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= finish;
            if (finish) begin
                rsp_rdata <= rdata_n;
                st_q      <= F_IDLE;
            end else if (req_valid && req_ready) begin
                st_q    <= F_ACT;
                we_q    <= req_we;
                tag_q   <= req_addr[ADDR_W-1:IDX_W];
                idx_q   <= req_addr[IDX_W-1:0];
                wdata_q <= req_wdata;
            end
        end
    end

    // R3
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);
endmodule

// File: rtl/mesi_snoop_ctrl.sv
// Top of the per-core coherence controller. Joins line storage, the snoop
// responder and the core sequencer, and merges their bus requests: a pending
// snoop write-back goes first, and nothing is requested during a snoop.
// Assumes a grant completes the transaction in the same cycle.
module mesi_snoop_ctrl
    import mesi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 16,
    parameter int LINES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_req_valid,
    output logic              core_req_ready,
    input  logic              core_req_we,
    input  logic [ADDR_W-1:0] core_req_addr,
    input  logic [DATA_W-1:0] core_req_wdata,
    output logic              core_rsp_valid,
    output logic [DATA_W-1:0] core_rsp_rdata,
    output logic              bus_req_valid,
    output logic [1:0]        bus_req_cmd,
    output logic [ADDR_W-1:0] bus_req_addr,
    output logic [DATA_W-1:0] bus_req_wdata,
    input  logic              bus_gnt,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_shared_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    output logic              snp_shared,
    output logic              snp_dirty
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [IDX_W-1:0]  c_idx;
    logic [TAG_W-1:0]  c_tag, s_tag, cw_tag;
    mesi_t             c_state, s_state, cw_state, sw_state;
    logic [DATA_W-1:0] c_data, s_data, cw_data;
    logic              cw_en, cw_data_en, sw_en;
    logic              wb_pend, wb_done, core_gnt;
    logic [ADDR_W-1:0] wb_addr;
    logic [DATA_W-1:0] wb_data;
    logic              cq_valid;
    bus_cmd_t          cq_cmd;
    logic [ADDR_W-1:0] cq_addr;
    logic [DATA_W-1:0] cq_wdata;

    mesi_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .c_idx(c_idx), .c_tag(c_tag), .c_state(c_state), .c_data(c_data),
        .cw_en(cw_en), .cw_tag(cw_tag), .cw_state(cw_state),
        .cw_data_en(cw_data_en), .cw_data(cw_data),
        .s_idx(snp_addr[IDX_W-1:0]), .s_tag(s_tag), .s_state(s_state), .s_data(s_data),
        .sw_en(sw_en), .sw_state(sw_state)
    );

    mesi_snoop #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_snoop (
        .clk(clk), .rst_n(rst_n),
        .snp_valid(snp_valid), .snp_cmd(bus_cmd_t'(snp_cmd)), .snp_addr(snp_addr),
        .line_tag(s_tag), .line_state(s_state), .line_data(s_data),
        .shared(snp_shared), .dirty(snp_dirty), .sw_en(sw_en), .sw_state(sw_state),
        .wb_pend(wb_pend), .wb_addr(wb_addr), .wb_data(wb_data), .wb_done(wb_done)
    );

    mesi_core_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(core_req_valid), .req_ready(core_req_ready), .req_we(core_req_we),
        .req_addr(core_req_addr), .req_wdata(core_req_wdata),
        .rsp_valid(core_rsp_valid), .rsp_rdata(core_rsp_rdata),
        .snp_valid(snp_valid), .wb_pend(wb_pend),
        .c_idx(c_idx), .line_tag(c_tag), .line_state(c_state), .line_data(c_data),
        .cw_en(cw_en), .cw_tag(cw_tag), .cw_state(cw_state),
        .cw_data_en(cw_data_en), .cw_data(cw_data),
        .breq_valid(cq_valid), .breq_cmd(cq_cmd), .breq_addr(cq_addr), .breq_wdata(cq_wdata),
        .bgnt(core_gnt), .brdata(bus_rdata), .bshared(bus_shared_in)
    );

    // Bus request merge: snoop write-back first, nothing while a snoop is present.
    always_comb begin
        bus_req_valid = !snp_valid && (wb_pend || cq_valid);
        bus_req_cmd   = wb_pend ? CMD_WB : cq_cmd;
        bus_req_addr  = wb_pend ? wb_addr : cq_addr;
        bus_req_wdata = wb_pend ? wb_data : cq_wdata;
        wb_done       = bus_gnt && bus_req_valid && wb_pend;
        core_gnt      = bus_gnt && bus_req_valid && !wb_pend;
    end

    // R12
    snoop_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_valid |-> !core_req_ready && !bus_req_valid);
    // R13
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_valid && !bus_gnt && !snp_valid |=> $stable(bus_req_addr) && $stable(bus_req_cmd));
    // R9
    dirty_then_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
        snp_dirty |=> bus_req_cmd == CMD_WB);
endmodule

// File: tb/tb_mesi_snoop_ctrl.sv
module tb_mesi_snoop_ctrl;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic core_req_valid = 0, core_req_we = 0;
    logic [ADDR_W-1:0] core_req_addr = '0;
    logic [DATA_W-1:0] core_req_wdata = '0;
    logic core_req_ready, core_rsp_valid;
    logic [DATA_W-1:0] core_rsp_rdata;
    logic bus_req_valid;
    logic [1:0] bus_req_cmd;
    logic [ADDR_W-1:0] bus_req_addr;
    logic [DATA_W-1:0] bus_req_wdata;
    logic bus_gnt = 0, bus_shared_in = 0;
    logic [DATA_W-1:0] bus_rdata = '0;
    logic snp_valid = 0;
    logic [1:0] snp_cmd = '0;
    logic [ADDR_W-1:0] snp_addr = '0;
    logic snp_shared, snp_dirty;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [DATA_W-1:0] mem [256];

    always #2 clk = ~clk;

    mesi_snoop_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(4)) dut (.*);

    // {we, addr, wdata, shared_in, ncmd, cmd0, cmd1, exp_rdata}
    localparam int NV = 9;
    localparam logic [47:0] VEC [NV] = '{
        {1'b0, 8'h10, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0, 16'h1070}, // R2 miss, E
        {1'b1, 8'h10, 16'hA001, 1'b0, 2'd0, 2'd0, 2'd0, 16'hA001}, // R4 E write
        {1'b1, 8'h10, 16'hA002, 1'b0, 2'd0, 2'd0, 2'd0, 16'hA002}, // R4 M write
        {1'b0, 8'h10, 16'h0000, 1'b0, 2'd0, 2'd0, 2'd0, 16'hA002}, // R3 hit
        {1'b0, 8'h21, 16'h0000, 1'b1, 2'd1, 2'd0, 2'd0, 16'h10E7}, // R2 miss, S
        {1'b1, 8'h21, 16'hB001, 1'b0, 2'd1, 2'd2, 2'd0, 16'hB001}, // R5 upgrade
        {1'b0, 8'h11, 16'h0000, 1'b0, 2'd2, 2'd3, 2'd0, 16'h1077}, // R7 dirty victim
        {1'b1, 8'h22, 16'hC001, 1'b0, 2'd1, 2'd1, 2'd0, 16'hC001}, // R6 write miss
        {1'b0, 8'h21, 16'h0000, 1'b0, 2'd1, 2'd0, 2'd0, 16'hB001}  // R7 clean victim, R2
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic run_core(input logic we, input logic [7:0] addr, input logic [15:0] wd,
                            input logic shr, input int ncmd, input logic [1:0] c0,
                            input logic [1:0] c1, input logic [15:0] exp, input bit hold,
                            input string req);
        int n = 0;
        bit got = 0, held = 0, hchk = 0;
        logic [1:0] seen [2];
        logic [1:0] hcmd;
        logic [7:0] haddr;
        @(negedge clk);
        core_req_valid = 1; core_req_we = we; core_req_addr = addr; core_req_wdata = wd;
        while (!core_req_ready) @(negedge clk);
        @(posedge clk);
        for (int c = 0; c < 20 && !got; c++) begin
            @(negedge clk);
            core_req_valid = 0;
            bus_gnt = 0;
            if (core_rsp_valid) begin
                got = 1;
                check({req, " rsp data"}, core_rsp_rdata, exp);
            end else if (bus_req_valid) begin
                if (hold && !held) begin
                    held = 1; hcmd = bus_req_cmd; haddr = bus_req_addr;
                end else begin
                    if (held && !hchk) begin
                        hchk = 1;
                        check("R13 held cmd", bus_req_cmd, hcmd);
                        check("R13 held addr", bus_req_addr, haddr);
                    end
                    if (n < 2) seen[n] = bus_req_cmd;
                    n++;
                    if (bus_req_cmd == 2'd3) mem[bus_req_addr] = bus_req_wdata;
                    else bus_rdata = mem[bus_req_addr];
                    bus_shared_in = shr;
                    bus_gnt = 1;
                end
            end
        end
        bus_gnt = 0;
        check({req, " responded"}, got, 1);
        check({req, " bus cmd count"}, n, ncmd);
        if (n >= 1 && ncmd >= 1) check({req, " first cmd"}, seen[0], c0);
        if (n >= 2 && ncmd >= 2) check({req, " second cmd"}, seen[1], c1);
    endtask

    task automatic snoop(input logic [1:0] cmd, input logic [7:0] addr, input logic sh,
                         input logic dy, input logic [15:0] wb, input string req);
        @(negedge clk);
        snp_valid = 1; snp_cmd = cmd; snp_addr = addr;
        #1;
        check({req, " snp_shared"}, snp_shared, sh);
        check({req, " snp_dirty"}, snp_dirty, dy);
        @(negedge clk);
        snp_valid = 0;
        if (dy) begin
            #1;
            check({req, " wb valid"}, bus_req_valid, 1);
            check({req, " wb cmd"}, bus_req_cmd, 2'd3);
            check({req, " wb addr"}, bus_req_addr, addr);
            check({req, " wb data"}, bus_req_wdata, wb);
            mem[bus_req_addr] = bus_req_wdata;
            bus_gnt = 1;
            @(negedge clk);
            bus_gnt = 0;
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 16'h1000 + 16'(i * 7);
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;
        #1;
        // R1 reset state
        check("R1 ready", core_req_ready, 1);
        check("R1 bus idle", bus_req_valid, 0);
        check("R1 no rsp", core_rsp_valid, 0);
        snoop(2'd0, 8'h10, 0, 0, 16'h0, "R1 invalid after reset");

        for (int v = 0; v < NV; v++) begin
            logic [47:0] e;
            e = VEC[v];
            run_core(e[47], e[46:39], e[38:23], e[22], int'(e[21:20]), e[19:18], e[17:16],
                     e[15:0], 0, $sformatf("vec%0d", v));
        end

        // R9 snoop read on Modified, then R8 on the now-Shared line
        snoop(2'd0, 8'h10, 0, 1, 16'hA002, "R9 dirty read");
        snoop(2'd0, 8'h10, 1, 0, 16'h0, "R8 shared after R9");
        // R11 tag miss changes nothing
        snoop(2'd0, 8'h30, 0, 0, 16'h0, "R11 tag miss");
        snoop(2'd0, 8'h10, 1, 0, 16'h0, "R11 line unchanged");
        // R10 upgrade invalidates a Shared line; refill from memory
        snoop(2'd2, 8'h10, 0, 0, 16'h0, "R10 upg on S");
        run_core(0, 8'h10, 16'h0, 1, 1, 2'd0, 2'd0, 16'hA002, 0, "R10 refetch");
        // R10 RFO on Modified: dirty + write-back + Invalid; R11 invalid hit
        snoop(2'd1, 8'h22, 0, 1, 16'hC001, "R10 rfo on M");
        snoop(2'd0, 8'h22, 0, 0, 16'h0, "R11 invalid hit");
        run_core(0, 8'h22, 16'h0, 0, 1, 2'd0, 2'd0, 16'hC001, 0, "R10 refetch C");

        // R12 race: pending upgrade on 0x10 (S) overtaken by a snooped upgrade
        @(negedge clk);
        core_req_valid = 1; core_req_we = 1; core_req_addr = 8'h10; core_req_wdata = 16'hD001;
        while (!core_req_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        core_req_valid = 0;
        snp_valid = 1; snp_cmd = 2'd2; snp_addr = 8'h10;
        #1;
        check("R12 bus quiet in snoop", bus_req_valid, 0);
        check("R12 not ready in snoop", core_req_ready, 0);
        @(negedge clk);
        snp_valid = 0;
        #1;
        check("R12 request back", bus_req_valid, 1);
        check("R12 reissued as rfo", bus_req_cmd, 2'd1);
        bus_rdata = mem[8'h10]; bus_gnt = 1;
        @(negedge clk);
        bus_gnt = 0;
        check("R12 rsp", core_rsp_valid, 1);
        check("R12 rsp data", core_rsp_rdata, 16'hD001);
        snoop(2'd0, 8'h10, 0, 1, 16'hD001, "R12 line now M");

        // R8 snoop read on Exclusive 0x21 -> Shared, seen by a later upgrade (R5, R13)
        snoop(2'd0, 8'h21, 1, 0, 16'h0, "R8 E to S");
        run_core(1, 8'h21, 16'hB002, 0, 1, 2'd2, 2'd0, 16'hB002, 1, "R5 after R8");
        snoop(2'd2, 8'h21, 0, 1, 16'hB002, "R10 upg on M");

        finish_run();
    end
endmodule